// File: doc/BRIEF.md
# Free-Running Timer with Coherent Byte Reads

This block holds a 16-bit up-counter that advances once every four bus clocks through a fixed prescaler, so its value repeats every 262,144 clocks. Software reads it one byte at a time over an 8-bit register bus. Two register pairs expose the counter: a primary pair and a secondary pair. Reading either high byte freezes the current low byte in a hold buffer, so a high-then-low read returns a coherent 16-bit value even when the low byte changes between the two reads.

An overflow flag is set each time the counter wraps from all ones to zero. The interrupt line is asserted while that flag and its enable bit are both 1. Software clears the flag with two reads: a status read taken while the flag is set, then a read of the primary low byte. Reads through the secondary pair never clear the flag. This lets a routine sample the time without losing a pending overflow. A write to offset 3 reloads the counter and the prescaler and abandons any half-done byte read. It does not change the flag or the enable bit.

The bus is a plain single-cycle register port and has no back-pressure. A read is served in the cycle its strobe is high. A write is taken at the edge that ends that cycle.

Top module: `frt_timer`

## Requirements
- R1: While reset is held, and after it is released, the counter is 0xFFFC with the prescaler at zero, and the flag, the enable bit and `irq` are 0. Writes to offsets 0, 1, 2 and 5 have no effect on any state.
- R2: The counter increases by one at every fourth rising clock edge after reset, and wraps from 0xFFFF to 0x0000.
- R3: Offset 0 returns the counter's high byte in the primary pair and offset 2 returns it in the secondary pair. Reading either one, with no sequence pending, copies the live low byte into the hold buffer and opens a sequence.
- R4: A high-byte read while a sequence is already pending leaves the hold buffer unchanged.
- R5: Offsets 1 and 3 return the low byte. They return the hold buffer if a sequence is pending, and that read ends the sequence. They return the live low byte if no sequence is pending.
- R6: The overflow flag is set at the edge where the counter wraps. Offset 5 returns the flag in bit 5 and zeros in its other bits.
- R7: Offset 4 is read/write and stores only bit 5 as the interrupt enable. `irq` is 1 exactly when the flag and the enable bit are both 1.
- R8: A read of offset 5 while the flag is 1 arms a clear. The next read of offset 1 clears the flag and uses up the arm.
- R9: A read of offset 3 never clears the flag and does not use up an armed clear.
- R10: A write of any value to offset 3 reloads the counter to 0xFFFC, resets the prescaler to zero and ends any pending sequence. It leaves the flag, the arm and the enable bit unchanged.
- R11: If a reload write arrives in the cycle where the prescaler would advance the counter, the reload wins and the counter holds 0xFFFC.
- R12: If an armed offset-1 read happens in the same cycle as a wrap, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_rd | input | 1 | Read strobe for one cycle |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of `bus_rd` |
| irq | output | 1 | Overflow interrupt request |

## Verification
Read data is combinational, so it is due in the same cycle that `bus_rd` is high. Everything a bus access changes becomes visible one edge later: the hold buffer, the arm, the flag clear, the enable and the reload. The counter value shown at any moment is 0xFFFC plus the number of edges since the last reset or reload, divided by four, and `irq` follows the flag with no extra register. The bench drives each access just after a falling edge and samples 1 ns later. It keeps its own count of edges since the last reset or reload to predict the counter. It waits for exact edge counts so that reloads and reads land on terminal-count and wrap cycles.

// File: rtl/frt_pkg.sv
`timescale 1ns/1ps
package frt_pkg;
  // Register offsets on the byte bus
  typedef enum logic [2:0] {
    REG_CNT_HI = 3'd0,
    REG_CNT_LO = 3'd1,
    REG_ALT_HI = 3'd2,
    REG_ALT_LO = 3'd3,
    REG_CTRL   = 3'd4,
    REG_STAT   = 3'd5
  } frt_reg_e;

  // Bit position of the flag in status and of the enable in control
  localparam int FLAG_BIT = 5;
endpackage

// File: rtl/frt_counter.sv
`timescale 1ns/1ps
module frt_counter #(
  parameter int                CNT_W     = 16,
  parameter int                PRE_DIV   = 4,
  parameter logic [CNT_W-1:0]  RESET_VAL = 16'hFFFC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             tick;

  generate
    if (PRE_DIV <= 1) begin : g_nodiv
      assign tick = 1'b1;
    end else begin : g_div
      localparam int PW = $clog2(PRE_DIV);
      logic [PW-1:0] pre_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          pre_q <= '0;
        else if (clr_i)                      pre_q <= '0;
        else if (pre_q == PW'(PRE_DIV - 1))  pre_q <= '0;
        else                                 pre_q <= pre_q + 1'b1;
      end
      assign tick = (pre_q == PW'(PRE_DIV - 1));
    end
  endgenerate

  // Reload takes priority over a terminal count in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= RESET_VAL;
    else if (clr_i)  cnt_q <= RESET_VAL;
    else if (tick)   cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = tick && (cnt_q == '1) && !clr_i;

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clr_i) |-> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));

  assert_wrap_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> (cnt_q == '0));

  assert_reload_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == RESET_VAL));
endmodule

// File: rtl/frt_latch.sv
`timescale 1ns/1ps
module frt_latch #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hi_rd_i,
  input  logic              lo_rd_i,
  input  logic              clr_i,
  input  logic [BYTE_W-1:0] live_lo_i,
  output logic              pending_o,
  output logic [BYTE_W-1:0] hold_o
);
  logic              pend_q;
  logic [BYTE_W-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      hold_q <= '0;
    end else if (clr_i) begin
      pend_q <= 1'b0;
    end else if (hi_rd_i && !pend_q) begin
      pend_q <= 1'b1;
      hold_q <= live_lo_i;
    end else if (lo_rd_i) begin
      pend_q <= 1'b0;
    end
  end

  assign pending_o = pend_q;
  assign hold_o    = hold_q;

  assert_hold_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |=> $stable(hold_q));

  assert_lo_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lo_rd_i |=> !pend_q);

  assert_cancel_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !pend_q);
endmodule

// File: rtl/frt_flag.sv
`timescale 1ns/1ps
module frt_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic wrap_i,
  input  logic stat_rd_i,
  input  logic main_lo_rd_i,
  input  logic en_wr_i,
  input  logic en_wdata_i,
  output logic flag_o,
  output logic en_o,
  output logic irq_o
);
  logic flag_q, arm_q, en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    arm_q <= 1'b0;
    else if (main_lo_rd_i)         arm_q <= 1'b0;
    else if (stat_rd_i && flag_q)  arm_q <= 1'b1;
  end

  // Setting on a wrap outranks an armed clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        flag_q <= 1'b0;
    else if (wrap_i)                   flag_q <= 1'b1;
    else if (main_lo_rd_i && arm_q)    flag_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        en_q <= 1'b0;
    else if (en_wr_i)  en_q <= en_wdata_i;
  end

  assign flag_o = flag_q;
  assign en_o   = en_q;
  assign irq_o  = flag_q & en_q;

  assert_rise_on_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(wrap_i));

  assert_fall_needs_arm_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(arm_q && main_lo_rd_i));

  assert_wrap_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_i |=> flag_q);
endmodule

// File: rtl/frt_timer.sv
`timescale 1ns/1ps
module frt_timer #(
  parameter int                   BYTE_W    = 8,
  parameter int                   PRE_DIV   = 4,
  parameter logic [2*BYTE_W-1:0]  RESET_VAL = 16'hFFFC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [2:0]        bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              irq
);
  import frt_pkg::*;

  localparam int CNT_W = 2 * BYTE_W;

  logic [CNT_W-1:0]  cnt;
  logic              wrap;
  logic              pending;
  logic [BYTE_W-1:0] hold;
  logic              flag, en;
  logic              unused_wdata;

  // Address decode
  logic rd_main_hi, rd_main_lo, rd_alt_hi, rd_alt_lo, rd_stat;
  logic cnt_clr, en_wr;

  assign rd_main_hi = bus_rd && (bus_addr == REG_CNT_HI);
  assign rd_main_lo = bus_rd && (bus_addr == REG_CNT_LO);
  assign rd_alt_hi  = bus_rd && (bus_addr == REG_ALT_HI);
  assign rd_alt_lo  = bus_rd && (bus_addr == REG_ALT_LO);
  assign rd_stat    = bus_rd && (bus_addr == REG_STAT);
  assign cnt_clr    = bus_wr && (bus_addr == REG_ALT_LO);
  assign en_wr      = bus_wr && (bus_addr == REG_CTRL);
  assign unused_wdata = ^bus_wdata;

  frt_counter #(
    .CNT_W     (CNT_W),
    .PRE_DIV   (PRE_DIV),
    .RESET_VAL (RESET_VAL)
  ) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (cnt_clr),
    .cnt_o  (cnt),
    .wrap_o (wrap)
  );

  frt_latch #(.BYTE_W(BYTE_W)) u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .hi_rd_i   (rd_main_hi || rd_alt_hi),
    .lo_rd_i   (rd_main_lo || rd_alt_lo),
    .clr_i     (cnt_clr),
    .live_lo_i (cnt[BYTE_W-1:0]),
    .pending_o (pending),
    .hold_o    (hold)
  );

  frt_flag u_flag (
    .clk          (clk),
    .rst_n        (rst_n),
    .wrap_i       (wrap),
    .stat_rd_i    (rd_stat),
    .main_lo_rd_i (rd_main_lo),
    .en_wr_i      (en_wr),
    .en_wdata_i   (bus_wdata[FLAG_BIT]),
    .flag_o       (flag),
    .en_o         (en),
    .irq_o        (irq)
  );

  // Read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        REG_CNT_HI, REG_ALT_HI: bus_rdata = cnt[CNT_W-1:BYTE_W];
        REG_CNT_LO, REG_ALT_LO: bus_rdata = pending ? hold : cnt[BYTE_W-1:0];
        REG_CTRL:               bus_rdata[FLAG_BIT] = en;
        REG_STAT:               bus_rdata[FLAG_BIT] = flag;
        default:                bus_rdata = '0;
      endcase
    end
  end

  assert_alt_keeps_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_alt_lo && flag) |=> flag);

  assert_irq_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (en && flag));
endmodule

// File: tb/frt_timer_test.sv
`timescale 1ns/1ps
module frt_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_rd = 1'b0;
  logic       bus_wr = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int unsigned ncyc;

  always #2 clk = ~clk;

  frt_timer uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  // Edges since reset or since the last reload write
  always @(posedge clk) begin
    if (!rst_n)                          ncyc <= 0;
    else if (bus_wr && bus_addr == 3'd3) ncyc <= 0;
    else                                 ncyc <= ncyc + 1;
  end

  function automatic logic [15:0] exp_cnt();
    return 16'hFFFC + 16'(ncyc / 4);
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] v);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // {req, chk, rd, wr, addr, wdata, exp_rdata, exp_irq}
  localparam int NV = 21;
  localparam logic [26:0] VEC [NV] = '{
    {4'd3,  1'b1, 1'b1, 1'b0, 3'd0, 8'h00, 8'hFF, 1'b0}, // R3 high, captures FC
    {4'd5,  1'b1, 1'b1, 1'b0, 3'd1, 8'h00, 8'hFC, 1'b0}, // R5 hold
    {4'd5,  1'b1, 1'b1, 1'b0, 3'd1, 8'h00, 8'hFC, 1'b0}, // R5 live
    {4'd3,  1'b1, 1'b1, 1'b0, 3'd2, 8'h00, 8'hFF, 1'b0}, // R3 alt high
    {4'd4,  1'b1, 1'b1, 1'b0, 3'd2, 8'h00, 8'hFF, 1'b0}, // R4 repeat high
    {4'd4,  1'b1, 1'b1, 1'b0, 3'd3, 8'h00, 8'hFC, 1'b0}, // R4 first capture kept
    {4'd5,  1'b1, 1'b1, 1'b0, 3'd3, 8'h00, 8'hFD, 1'b0}, // R5 live after end
    {4'd7,  1'b0, 1'b0, 1'b1, 3'd4, 8'h20, 8'h00, 1'b0}, // R7 enable
    {4'd7,  1'b1, 1'b1, 1'b0, 3'd4, 8'h00, 8'h20, 1'b0}, // R7 readback
    {4'd6,  1'b1, 1'b1, 1'b0, 3'd5, 8'h00, 8'h00, 1'b0}, // R6 no flag yet
    {4'd2,  1'b1, 1'b1, 1'b0, 3'd1, 8'h00, 8'hFE, 1'b0}, // R2 count FFFE
    {4'd2,  1'b1, 1'b1, 1'b0, 3'd0, 8'h00, 8'hFF, 1'b0}, // R2 high
    {4'd5,  1'b1, 1'b1, 1'b0, 3'd1, 8'h00, 8'hFE, 1'b0}, // R5 hold while live FF
    {4'd2,  1'b1, 1'b1, 1'b0, 3'd1, 8'h00, 8'hFF, 1'b0}, // R2 count FFFF
    {4'd6,  1'b0, 1'b0, 1'b0, 3'd0, 8'h00, 8'h00, 1'b0},
    {4'd6,  1'b0, 1'b0, 1'b0, 3'd0, 8'h00, 8'h00, 1'b0},
    {4'd6,  1'b1, 1'b1, 1'b0, 3'd5, 8'h00, 8'h20, 1'b1}, // R6 wrap sets flag
    {4'd9,  1'b1, 1'b1, 1'b0, 3'd3, 8'h00, 8'h00, 1'b1}, // R9 alt low
    {4'd9,  1'b1, 1'b1, 1'b0, 3'd5, 8'h00, 8'h20, 1'b1}, // R9 flag kept
    {4'd8,  1'b1, 1'b1, 1'b0, 3'd1, 8'h00, 8'h00, 1'b1}, // R8 main low clears
    {4'd8,  1'b1, 1'b1, 1'b0, 3'd5, 8'h00, 8'h00, 1'b0}  // R8 flag gone
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    // R1 reset state, read while reset held
    repeat (2) @(negedge clk);
    bus_rd = 1'b1;
    bus_addr = 3'd0; #1 check("R1 high", bus_rdata, 8'hFF);
    bus_addr = 3'd1; #1 check("R1 low", bus_rdata, 8'hFC);
    bus_addr = 3'd4; #1 check("R1 enable", bus_rdata, 8'h00);
    bus_addr = 3'd5; #1 check("R1 flag", bus_rdata, 8'h00);
    check("R1 irq", irq, 1'b0);
    bus_rd = 1'b0;
    @(negedge clk);

    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      logic [26:0] v;
      string tag;
      v = VEC[i];
      bus_rd = v[21]; bus_wr = v[20]; bus_addr = v[19:17]; bus_wdata = v[16:9];
      #1;
      tag = $sformatf("R%0d vec%0d", v[26:23], i);
      if (v[22]) check(tag, bus_rdata, v[8:1]);
      check({tag, " irq"}, irq, v[0]);
      @(negedge clk);
      bus_rd = 1'b0; bus_wr = 1'b0;
    end

    // R1 read-only counter, R10 reload cancels sequence and keeps enable
    wr(3'd0, 8'h12);
    wr(3'd1, 8'h34);
    rd(3'd0, d); check("R1 write ignored", d, exp_cnt() >> 8);
    wr(3'd3, 8'h5A);
    rd(3'd1, d); check("R10 live after reload", d, 8'hFC);
    rd(3'd4, d); check("R10 enable kept", d, 8'h20);

    // R11 reload on the terminal-count cycle
    while (ncyc % 4 != 3) @(negedge clk);
    wr(3'd3, 8'h00);
    rd(3'd1, d); check("R11 reload wins", d, 8'hFC);
    repeat (2) @(negedge clk);
    rd(3'd1, d); check("R11 prescaler restarted", d, 8'hFC);
    rd(3'd1, d); check("R11 first step", d, 8'hFD);

    // R7 gating, R6 wrap after reload
    while (ncyc != 20) @(negedge clk);
    check("R6 irq after wrap", irq, 1'b1);
    wr(3'd4, 8'h00);
    check("R7 irq masked", irq, 1'b0);
    rd(3'd5, d); check("R7 flag still set", d, 8'h20);
    wr(3'd4, 8'hFF);
    check("R7 irq back", irq, 1'b1);
    rd(3'd4, d); check("R7 only bit 5", d, 8'h20);

    // R2 long run through the secondary pair
    while (ncyc != 1024) @(negedge clk);
    rd(3'd2, d); check("R2 high after 1024", d, 8'h00);
    rd(3'd3, d); check("R2 low after 1024", d, 8'hFC);
    rd(3'd5, d); check("R9 flag survives alt reads", d, 8'h20);

    // R12 armed clear on the wrap cycle
    wr(3'd3, 8'h00);
    while (ncyc != 15) @(negedge clk);
    rd(3'd1, d); check("R12 low at FFFF", d, 8'hFF);
    rd(3'd5, d); check("R12 flag stays", d, 8'h20);

    // R9 alt low keeps the arm, R8 main low then clears
    rd(3'd3, d);
    rd(3'd1, d);
    rd(3'd5, d); check("R9 arm kept through alt", d, 8'h00);
    check("R8 irq cleared", irq, 1'b0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule